// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 128-byte serial memory reached over a two-wire bus. It oversamples the clock line and the data line with the system clock, spots START and STOP, and expects a first byte made of a 7-bit word address (MSB first) followed by a direction bit. A zero direction bit opens a write transfer. The data bytes that follow go into a small page buffer. A one opens a read transfer. Read data comes out from the current address, and the address moves forward every time the host acknowledges a byte.

The slave drives the data line only through an open-drain enable, which pulls the line low when asserted. Writes reach the storage array only when STOP arrives. That STOP also starts a timed internal write cycle. For the length of that cycle the slave refuses to acknowledge any address byte, so the host can poll until the write is done.

Top module: `eeprom_slave`

## Requirements
- R1: After reset the SDA pull-down enable is deasserted, no internal write cycle is running, and every array location reads as 0x00.
- R2: The slave acknowledges a first byte (7-bit address MSB first, then the direction bit, 1 = read, 0 = write) by holding SDA low through the ninth SCL pulse, when no internal write cycle is running.
- R3: A byte written to an address with a write transfer closed by STOP reads back unchanged from that address once the internal write cycle has ended.
- R4: The SDA pull-down enable changes only while SCL is low, except at START or STOP, and read data is shifted out MSB first.
- R5: In a read, each host ACK on the ninth clock moves to the next address, and the address wraps from 127 to 0.
- R6: A write transfer fills a 4-byte page buffer. Only the low 2 address bits advance, wrapping inside the page, so a fifth byte overwrites the first. All buffered bytes are stored together.
- R7: Received write data reaches the array only at STOP. A repeated START before STOP discards the buffered bytes and leaves the array unchanged.
- R8: For WRITE_CYCLES system clocks after the STOP of a write, address bytes receive no ACK. After that they are acknowledged again.
- R9: When the host leaves SDA high on the ninth clock of a read byte, the slave stops driving SDA until the next START.
- R10: A START or STOP in the middle of a byte abandons it, returns the slave to idle and leaves SDA released. A following complete transaction then works normally.
- R11: Every data byte received in a write transfer is acknowledged on its ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| sdaOe | output | 1 | When 1, pull the data line low (open drain) |

## Verification
Writes are tried in three forms: a single byte, a full page entered off its first slot, and an overlong page. The results tell correct slot wrapping apart from linear address growth and from plain overwrite. Reads are tried as single bytes and as streams that cross address 127, which separates wrap-to-zero from counter saturation. A write aborted by a repeated START, a read ended by NACK, and bytes cut off by STOP or START show that the array changes only at STOP and that the slave lets go of the line. Polling right after a STOP and again after WRITE_CYCLES clocks separates an honest busy window from one that never ends or never starts.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } bus_state_t;

  typedef struct packed {
    logic              loadAddr;
    logic              bufWrite;
    logic              readAdvance;
    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wrData;
  } ctrl_strobe_t;
endpackage

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl
  import eeprom_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               busy,
  input  logic [BYTE_W-1:0]  rdByte,
  output ctrl_strobe_t       strb,
  output logic               sdaOe
);
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  logic sclQ, sclP, sdaQ, sdaP;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1; sclP <= 1'b1; sdaQ <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn; sclP <= sclQ; sdaQ <= sdaIn; sdaP <= sdaQ;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclQ & ~sclP;
  assign sclFall  = ~sclQ & sclP;
  assign startDet = sclQ & sclP & sdaP & ~sdaQ;
  assign stopDet  = sclQ & sclP & ~sdaP & sdaQ;

  bus_state_t        state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic              isRead, pending, hostAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      pending <= 1'b0;
      hostAck <= 1'b0;
      sdaOe   <= 1'b0;
      strb    <= '0;
    end else begin
      strb.loadAddr    <= 1'b0;
      strb.bufWrite    <= 1'b0;
      strb.readAdvance <= 1'b0;
      strb.commit      <= 1'b0;
      if (startDet) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        sdaOe   <= 1'b0;
        pending <= 1'b0;
        hostAck <= 1'b0;
      end else if (stopDet) begin
        strb.commit <= pending;
        pending     <= 1'b0;
        state       <= ST_IDLE;
        sdaOe       <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDATA: begin
            if (sclRise && bitCnt < BITS_PER_BYTE) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaQ};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (busy) begin
                  state <= ST_IDLE;
                end else begin
                  sdaOe         <= 1'b1;
                  state         <= ST_ADDR_ACK;
                  isRead        <= rxShift[0];
                  strb.loadAddr <= 1'b1;
                  strb.addr     <= rxShift[BYTE_W-1:1];
                end
              end else begin
                sdaOe         <= 1'b1;
                state         <= ST_WDATA_ACK;
                strb.bufWrite <= 1'b1;
                strb.wrData   <= rxShift;
                pending       <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (isRead) begin
                state   <= ST_RDATA;
                txShift <= rdByte;
                sdaOe   <= ~rdByte[BYTE_W-1];
              end else begin
                state <= ST_WDATA;
                sdaOe <= 1'b0;
              end
            end
          end
          ST_WDATA_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclRise && bitCnt < BITS_PER_BYTE) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == BITS_PER_BYTE) begin
                sdaOe   <= 1'b0;
                bitCnt  <= '0;
                hostAck <= 1'b0;
                state   <= ST_RDATA_ACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaOe   <= ~txShift[BYTE_W-2];
              end
            end
          end
          ST_RDATA_ACK: begin
            if (sclRise) begin
              if (!sdaQ) begin
                hostAck          <= 1'b1;
                strb.readAdvance <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else if (sclFall && hostAck) begin
              hostAck <= 1'b0;
              state   <= ST_RDATA;
              txShift <= rdByte;
              sdaOe   <= ~rdByte[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: output held while the clock line stays high, unless START/STOP
  p_sda_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ && $past(sclQ) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  // R8: an address byte completed while busy is not acknowledged
  p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && bitCnt == BITS_PER_BYTE && busy && !startDet && !stopDet)
      |=> !sdaOe);

  // R2: line held low for the whole address acknowledge slot
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK) |-> sdaOe);

  // R9: idle slave never pulls the line
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_pkg::*;
#(
  parameter int unsigned PAGE_BYTES   = 4,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  output logic              busy,
  output logic [BYTE_W-1:0] rdByte
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
  localparam int unsigned CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [BYTE_W-1:0] mem     [DEPTH];
  logic [BYTE_W-1:0] bufData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [ADDR_W-1:0]     curAddr;
  logic [CNT_W-1:0]      timer;
  logic [ADDR_W-PAGE_W-1:0] pageBase;
  logic [PAGE_W-1:0]        slot;

  assign pageBase = curAddr[ADDR_W-1:PAGE_W];
  assign slot     = curAddr[PAGE_W-1:0];
  assign busy     = (timer != '0);
  assign rdByte   = mem[curAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      bufValid <= '0;
      timer    <= '0;
      for (int i = 0; i < int'(PAGE_BYTES); i++) bufData[i] <= '0;
    end else begin
      if (strb.loadAddr) begin
        curAddr  <= strb.addr;
        bufValid <= '0;
      end else if (strb.bufWrite) begin
        bufData[slot]  <= strb.wrData;
        bufValid[slot] <= 1'b1;
        curAddr        <= {pageBase, PAGE_W'(slot + 1'b1)};
      end else if (strb.readAdvance) begin
        curAddr <= curAddr + 1'b1;
      end
      if (strb.commit) begin
        timer    <= CNT_W'(WRITE_CYCLES);
        bufValid <= '0;
      end else if (busy) begin
        timer <= timer - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < int'(DEPTH); j++) mem[j] <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < int'(PAGE_BYTES); i++)
        if (bufValid[i]) mem[{pageBase, PAGE_W'(i)}] <= bufData[i];
    end
  end

  // R8: a new write cycle is launched only from idle, and busy follows it
  p_commit_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !busy);
  p_busy_after_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> busy);

  // R6: buffered writes never leave the current page
  p_page_stays_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |=> (curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W])));

  // R5: stream address wraps from the top of the array to zero
  p_seq_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readAdvance && !strb.loadAddr && curAddr == {ADDR_W{1'b1}}) |=> (curAddr == '0));
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int unsigned PAGE_BYTES   = 4,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  ctrl_strobe_t      strb;
  logic              busy;
  logic [BYTE_W-1:0] rdByte;

  eeprom_bus_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .busy   (busy),
    .rdByte (rdByte),
    .strb   (strb),
    .sdaOe  (sdaOe)
  );

  eeprom_store #(
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) i_store (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .busy   (busy),
    .rdByte (rdByte)
  );
endmodule

// File: tb/test_eeprom_slave.sv
module test_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 200;
  localparam int HI         = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaLine;
  assign sdaLine = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_slave #(.PAGE_BYTES(4), .WRITE_CYCLES(WCYC)) i_eeprom_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  int tests = 0, fails = 0, cyc = 0, stableViol = 0;
  bit finished = 1'b0;
  logic [7:0] model [128];
  logic [7:0] expQ[$];
  logic [7:0] actQ[$];
  string      tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = actQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  // R4 line monitor: slave output must not move while SCL stays high
  initial begin
    logic pScl, pOe;
    pScl = 1'b1; pOe = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && pScl && sclDrv && sdaOe != pOe) stableViol++;
      pScl = sclDrv; pOe = sdaOe;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(3);
    sclDrv = 1'b1; tick(HI);
    sdaDrv = 1'b0; tick(HI);
    sclDrv = 1'b0; tick(3);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(3);
    sclDrv = 1'b1; tick(HI);
    sdaDrv = 1'b1; tick(HI);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; tick(3);
    sclDrv = 1'b1; tick(HI);
    sclDrv = 1'b0; tick(3);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaDrv = 1'b1; tick(3);
    sclDrv = 1'b1; tick(HI/2);
    ack = ~sdaLine;
    tick(HI/2);
    sclDrv = 1'b0; tick(3);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; tick(3);
      sclDrv = 1'b1; tick(HI/2);
      v[i] = sdaLine;
      tick(HI/2);
      sclDrv = 1'b0; tick(3);
    end
    sdaDrv = ~giveAck; tick(3);
    sclDrv = 1'b1; tick(HI);
    sclDrv = 1'b0; tick(3);
    sdaDrv = 1'b1;
  endtask

  task automatic writeBytes(input logic [6:0] addr, input logic [7:0] d [8], input int n);
    logic ack;
    busStart();
    sendByte({addr, 1'b0}, ack);
    check(ack, "R2 write address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], ack);
      check(ack, "R11 data byte ack", ack, 1);
      model[{addr[6:2], 2'(addr[1:0] + 2'(i))}] = d[i];
    end
    busStop();
    tick(WCYC + 20);
  endtask

  task automatic readSeq(input logic [6:0] addr, input int n, input string tag);
    logic ack;
    logic [7:0] v;
    busStart();
    sendByte({addr, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(model[7'(addr + 7'(i))]);
      tagQ.push_back(tag);
      recvByte(i < n - 1, v);
      actQ.push_back(v);
    end
    busStop();
    tick(4);
  endtask

  initial begin
    logic [7:0] d [8];
    logic ack;
    logic [7:0] v;
    int stopCyc;
    for (int k = 0; k < 128; k++) model[k] = 8'h00;
    for (int k = 0; k < 8; k++) d[k] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(3);

    // R1: released line and cleared array after reset
    check(sdaOe == 1'b0, "R1 reset sdaOe", sdaOe, 0);
    readSeq(7'h05, 1, "R1 reset content");

    // R3: single byte write and readback
    d[0] = 8'hA5;
    writeBytes(7'h15, d, 1);
    readSeq(7'h15, 1, "R3 byte readback");

    // R5: stream across the top of the array
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    writeBytes(7'h7C, d, 4);
    d[0] = 8'h55; d[1] = 8'h66; d[2] = 8'h77; d[3] = 8'h88;
    writeBytes(7'h00, d, 4);
    readSeq(7'h7E, 5, "R5 sequential wrap");

    // R6: six bytes from slot 1 wrap inside page 0x20
    d[0] = 8'hC0; d[1] = 8'hC1; d[2] = 8'hC2; d[3] = 8'hC3; d[4] = 8'hC4; d[5] = 8'hC5;
    writeBytes(7'h21, d, 6);
    readSeq(7'h20, 5, "R6 page wrap");

    // R7: repeated START discards buffered byte
    busStart();
    sendByte({7'h40, 1'b0}, ack);
    check(ack, "R7 address ack", ack, 1);
    sendByte(8'h77, ack);
    check(ack, "R11 data ack before restart", ack, 1);
    busStart();
    sendByte({7'h40, 1'b1}, ack);
    check(ack, "R7 no write cycle after restart", ack, 1);
    expQ.push_back(8'h00); tagQ.push_back("R7 array unchanged");
    recvByte(1'b0, v);
    actQ.push_back(v);
    busStop();
    tick(4);

    // R8: busy polling
    busStart();
    sendByte({7'h50, 1'b0}, ack);
    sendByte(8'h3C, ack);
    model[7'h50] = 8'h3C;
    busStop();
    stopCyc = cyc;
    busStart();
    sendByte({7'h50, 1'b1}, ack);
    check(!ack, "R8 nack while busy", ack, 0);
    check(sdaOe == 1'b0, "R8 line released while busy", sdaOe, 0);
    busStop();
    while (cyc < stopCyc + WCYC + 5) tick(1);
    readSeq(7'h50, 1, "R8 data after write cycle");

    // R9: NACK ends read, line stays released
    busStart();
    sendByte({7'h15, 1'b1}, ack);
    expQ.push_back(8'hA5); tagQ.push_back("R9 single byte read");
    recvByte(1'b0, v);
    actQ.push_back(v);
    begin
      int held;
      held = 0;
      for (int i = 0; i < 9; i++) begin
        sdaDrv = 1'b1; tick(3);
        sclDrv = 1'b1; tick(HI/2);
        if (sdaOe) held++;
        tick(HI/2);
        sclDrv = 1'b0; tick(3);
      end
      check(held == 0, "R9 released after nack", held, 0);
    end
    busStop();
    tick(4);

    // R10: aborted bytes
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop();
    tick(4);
    check(sdaOe == 1'b0, "R10 released after stop abort", sdaOe, 0);
    busStart();
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    busStart();
    sendByte({7'h15, 1'b1}, ack);
    check(ack, "R10 ack after start abort", ack, 1);
    expQ.push_back(8'hA5); tagQ.push_back("R10 read after abort");
    recvByte(1'b0, v);
    actQ.push_back(v);
    busStop();
    tick(10);

    check(stableViol == 0, "R4 SDA stable while SCL high", stableViol, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule